// File: doc/BRIEF.md
# CAN Bit Timing and Resynchronization Unit

This block produces the time-quantum tick and walks each CAN bit through its four segments: a one-quantum sync segment, a propagation segment, phase segment 1 and phase segment 2. The clock is first divided by a power of two picked by a select field, then by a quantum prescaler of 2×(P+1). Each segment length and the resynchronization jump width are programmed as "length minus one" codes. They are captured only while `enable` is low. A legality checker rejects bad combinations, and the unit stays idle while the captured set is illegal.

After enable, the unit waits on an idle bus. The first falling (recessive-to-dominant) edge on the synchronized receive line starts a bit (hard synchronization). After that, falling edges that land outside the sync segment adjust the current bit, at most once per bit. A late edge stretches phase segment 1 and an early edge trims phase segment 2, each by the phase error capped at the jump width. The receive line is sampled where phase segment 1 ends. The block gives a one-cycle sample strobe with the sampled bit, and a one-cycle strobe when each bit starts. A protocol engine uses these strobes to drive frame decoding.

Top module: `can_bit_timing`

## Requirements
- R1: Configuration inputs are captured on every clock edge while `enable` is low and held unchanged while `enable` is high; input changes while enabled alter neither `cfg_bad` nor bit timing.
- R2: With lengths prop=`prop_len`+1, ph1=`ph1_len`+1, ph2=`ph2_len`+1, sjw=`sjw_len`+1 Tq, `cfg_bad` is 1 when `pre_sel`>4, ph1<2, ph2<2, ph1<ph2, ph1<sjw, sjw≥2 with ph2<sjw, or 1+prop+ph1+ph2 is outside 8..25; while `cfg_bad` is 1 no tick, sample strobe or bit-start strobe is produced.
- R3: While running, `tq_tick` is high for one cycle every 2^`pre_sel` × 2×(`brp`+1) clock cycles.
- R4: After enable the unit is idle and gives no bit start; the first falling edge of `rx` performs a hard synchronization, with `bit_start` high after the third rising clock edge following the fall of `rx`.
- R5: A bit with no resynchronization lasts 1+prop+ph1+ph2 quanta; `sample_stb` comes 1+prop+ph1 quanta after `bit_start`, with `sample_bit` equal to the synchronized `rx` at that point.
- R6: A falling edge detected during the sync segment changes neither the bit length nor the sample point.
- R7: A falling edge detected in the propagation segment or phase segment 1 lengthens phase segment 1 by min(e, sjw) quanta, where e is the quantum index counted from 1 at the first quantum after the sync segment.
- R8: A falling edge detected in phase segment 2 shortens it by min(r, sjw) quanta, r being the quanta left in that segment including the current one; the bit never ends before the end of the current quantum.
- R9: At most one resynchronization is applied per bit; later edges in the same bit are ignored.
- R10: `sample_stb` and `bit_start` are one-cycle pulses and are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run request; configuration is captured while low |
| pre_sel | input | 3 | Power-of-two predivider select (divide by 2^pre_sel, 0..4) |
| brp | input | 4 | Quantum prescaler value P, divide by 2×(P+1) |
| prop_len | input | 3 | Propagation segment length minus one |
| ph1_len | input | 3 | Phase segment 1 length minus one |
| ph2_len | input | 3 | Phase segment 2 length minus one |
| sjw_len | input | 2 | Jump width minus one |
| rx | input | 1 | Receive line, 1 is recessive |
| tq_tick | output | 1 | One-cycle time-quantum tick |
| sample_stb | output | 1 | One-cycle strobe at the sample point |
| sample_bit | output | 1 | Receive value captured at the last sample point |
| bit_start | output | 1 | One-cycle strobe at the start of each bit |
| cfg_bad | output | 1 | Captured configuration is illegal |

## Verification
The bench targets the legality limits on both sides of each rule. These are the 7 and 8 quantum bit totals, a jump width above phase segment 2, and a predivider select one past the largest. A checker that was off by one would let an unsafe bit run or reject a usable one. Late edges are placed where the phase error is below, equal to and above the jump width, and early edges are placed where the trim is capped. A missing cap or a wrong error index then shows up as a bit that is too long or too short, or as a sample point that has moved. A second edge inside an already corrected bit is aimed at a design that resynchronizes twice, and an edge in the sync segment is aimed at one that adjusts when it should not. Bus-idle and changes made while enabled show whether hard synchronization and the configuration capture leak.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
   typedef enum logic [1:0] {
      SEG_SYNC = 2'd0,
      SEG_PROP = 2'd1,
      SEG_PH1  = 2'd2,
      SEG_PH2  = 2'd3
   } seg_e;
endpackage

// File: rtl/bt_rx_sync.sv
module bt_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rx,
   output logic rx_s,
   output logic fall
);
   logic [STAGES-1:0] chain;
   logic              prev;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("bt_rx_sync needs at least two stages");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '1;
         prev  <= 1'b1;
      end else begin
         chain <= {chain[STAGES-2:0], rx};
         prev  <= chain[STAGES-1];
      end
   end

   assign rx_s = chain[STAGES-1];
   assign fall = prev & ~rx_s;

   AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> !fall); // R4
endmodule

// File: rtl/bt_prescale.sv
module bt_prescale #(
   parameter int PRE_SEL_W   = 3,
   parameter int PRE_MAX_LOG = 4,
   parameter int BRP_W       = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 run,
   input  logic                 restart,
   input  logic [PRE_SEL_W-1:0] pre_sel,
   input  logic [BRP_W-1:0]     brp,
   output logic                 tick
);
   localparam int PRE_CW = (PRE_MAX_LOG > 0) ? PRE_MAX_LOG : 1;
   localparam int QW     = BRP_W + 1;

   logic          pre_tick;
   logic [QW-1:0] q_cnt;
   logic [QW-1:0] q_term;

   generate
      if (PRE_MAX_LOG > 0) begin : g_predivider
         logic [PRE_CW-1:0] pre_cnt;
         logic [PRE_CW:0]   pre_full;
         assign pre_full = ((PRE_CW+1)'(1) << pre_sel) - (PRE_CW+1)'(1);
         assign pre_tick = (pre_cnt == pre_full[PRE_CW-1:0]);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                 pre_cnt <= '0;
            else if (!run || restart)   pre_cnt <= '0;
            else if (pre_tick)          pre_cnt <= '0;
            else                        pre_cnt <= pre_cnt + PRE_CW'(1);
         end
      end else begin : g_no_predivider
         logic unused_sel;
         assign unused_sel = ^pre_sel;
         assign pre_tick   = 1'b1;
      end
   endgenerate

   // 2*(P+1)-1 is P shifted left with a one appended
   assign q_term = {brp, 1'b1};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  q_cnt <= '0;
      else if (!run || restart)    q_cnt <= '0;
      else if (pre_tick) begin
         if (q_cnt == q_term)      q_cnt <= '0;
         else                      q_cnt <= q_cnt + QW'(1);
      end
   end

   assign tick = run & pre_tick & (q_cnt == q_term);

   AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick); // R3
endmodule

// File: rtl/bt_cfg_check.sv
module bt_cfg_check #(
   parameter int PRE_SEL_W   = 3,
   parameter int PRE_MAX_LOG = 4,
   parameter int SEG_W       = 3,
   parameter int SJW_W       = 2,
   parameter int MIN_BIT_TQ  = 8,
   parameter int MAX_BIT_TQ  = 25
) (
   input  logic [PRE_SEL_W-1:0] pre_sel,
   input  logic [SEG_W-1:0]     prop_len,
   input  logic [SEG_W-1:0]     ph1_len,
   input  logic [SEG_W-1:0]     ph2_len,
   input  logic [SJW_W-1:0]     sjw_len,
   output logic                 bad
);
   localparam int TW = SEG_W + 3;

   logic [TW-1:0] prop_tq, ph1_tq, ph2_tq, sjw_tq, total_tq;

   always_comb begin
      prop_tq  = TW'(prop_len) + TW'(1);
      ph1_tq   = TW'(ph1_len)  + TW'(1);
      ph2_tq   = TW'(ph2_len)  + TW'(1);
      sjw_tq   = TW'(sjw_len)  + TW'(1);
      total_tq = TW'(1) + prop_tq + ph1_tq + ph2_tq;
      bad = (pre_sel > PRE_SEL_W'(PRE_MAX_LOG))
          | (ph1_tq < TW'(2)) | (ph2_tq < TW'(2))
          | (ph1_tq < ph2_tq) | (ph1_tq < sjw_tq)
          | ((sjw_tq >= TW'(2)) & (ph2_tq < sjw_tq))
          | (total_tq < TW'(MIN_BIT_TQ)) | (total_tq > TW'(MAX_BIT_TQ));
   end
endmodule

// File: rtl/bt_seq.sv
module bt_seq
   import can_bt_pkg::*;
#(
   parameter int SEG_W = 3,
   parameter int SJW_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic             fall,
   input  logic             rx_s,
   input  logic [SEG_W-1:0] prop_len,
   input  logic [SEG_W-1:0] ph1_len,
   input  logic [SEG_W-1:0] ph2_len,
   input  logic [SJW_W-1:0] sjw_len,
   output logic             restart,
   output logic             sample_stb,
   output logic             sample_bit,
   output logic             bit_start
);
   localparam int LW = SEG_W + 2;

   seg_e          seg;
   logic          idle, used, seg_end, resync_ok;
   logic [LW-1:0] cnt, ext, shrink;
   logic [LW-1:0] prop_tq, ph1_tq, ph2_tq, sjw_tq, len_cur, perr, cap;

   always_comb begin
      prop_tq = LW'(prop_len) + LW'(1);
      ph1_tq  = LW'(ph1_len)  + LW'(1);
      ph2_tq  = LW'(ph2_len)  + LW'(1);
      sjw_tq  = LW'(sjw_len)  + LW'(1);
      case (seg)
         SEG_SYNC: len_cur = LW'(1);
         SEG_PROP: len_cur = prop_tq;
         SEG_PH1:  len_cur = ph1_tq + ext;
         SEG_PH2:  len_cur = ph2_tq - shrink;
         default:  len_cur = LW'(1);
      endcase
      case (seg)
         SEG_PROP: perr = cnt + LW'(1);
         SEG_PH1:  perr = prop_tq + cnt + LW'(1);
         SEG_PH2:  perr = ph2_tq - cnt;
         default:  perr = '0;
      endcase
      cap     = (perr > sjw_tq) ? sjw_tq : perr;
      seg_end = ((cnt + LW'(1)) >= len_cur);
   end

   assign restart   = run & idle & fall;
   assign resync_ok = run & ~idle & fall & ~used & (seg != SEG_SYNC);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idle <= 1'b1; seg <= SEG_SYNC; cnt <= '0; ext <= '0; shrink <= '0;
         used <= 1'b0; sample_stb <= 1'b0; sample_bit <= 1'b1; bit_start <= 1'b0;
      end else begin
         sample_stb <= 1'b0;
         bit_start  <= 1'b0;
         if (!run) begin
            idle <= 1'b1; seg <= SEG_SYNC; cnt <= '0;
            ext <= '0; shrink <= '0; used <= 1'b0;
         end else if (restart) begin
            idle <= 1'b0; seg <= SEG_SYNC; cnt <= '0;
            ext <= '0; shrink <= '0; used <= 1'b0;
            bit_start <= 1'b1;
         end else if (!idle) begin
            if (resync_ok) begin
               used <= 1'b1;
               if (seg == SEG_PH2) shrink <= cap;
               else                ext    <= cap;
            end
            if (tick) begin
               if (seg_end) begin
                  cnt <= '0;
                  case (seg)
                     SEG_SYNC: seg <= SEG_PROP;
                     SEG_PROP: seg <= SEG_PH1;
                     SEG_PH1: begin
                        seg        <= SEG_PH2;
                        sample_stb <= 1'b1;
                        sample_bit <= rx_s;
                     end
                     default: begin
                        seg       <= SEG_SYNC;
                        bit_start <= 1'b1;
                        ext       <= '0;
                        shrink    <= '0;
                        used      <= 1'b0;
                     end
                  endcase
               end else begin
                  cnt <= cnt + LW'(1);
               end
            end
         end
      end
   end

   AST_ONE_RESYNC: assert property (@(posedge clk) disable iff (!rst_n)
      !((ext != '0) && (shrink != '0))); // R9
   AST_STRETCH_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      ext <= sjw_tq); // R7
   AST_TRIM_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      shrink <= sjw_tq); // R8
   AST_STROBES_APART: assert property (@(posedge clk) disable iff (!rst_n)
      !(sample_stb && bit_start)); // R10
   AST_SAMPLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      sample_stb |=> !sample_stb); // R10
   AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      bit_start |=> !bit_start); // R10
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      idle |-> !sample_stb); // R4
endmodule

// File: rtl/can_bit_timing.sv
module can_bit_timing #(
   parameter int SYNC_STAGES = 2,
   parameter int PRE_SEL_W   = 3,
   parameter int PRE_MAX_LOG = 4,
   parameter int BRP_W       = 4,
   parameter int SEG_W       = 3,
   parameter int SJW_W       = 2,
   parameter int MIN_BIT_TQ  = 8,
   parameter int MAX_BIT_TQ  = 25
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 enable,
   input  logic [PRE_SEL_W-1:0] pre_sel,
   input  logic [BRP_W-1:0]     brp,
   input  logic [SEG_W-1:0]     prop_len,
   input  logic [SEG_W-1:0]     ph1_len,
   input  logic [SEG_W-1:0]     ph2_len,
   input  logic [SJW_W-1:0]     sjw_len,
   input  logic                 rx,
   output logic                 tq_tick,
   output logic                 sample_stb,
   output logic                 sample_bit,
   output logic                 bit_start,
   output logic                 cfg_bad
);
   generate
      if (SJW_W > SEG_W) begin : g_bad_sjw
         $error("jump width field wider than segment field");
      end
      if (MAX_BIT_TQ < MIN_BIT_TQ) begin : g_bad_range
         $error("bit length range is empty");
      end
   endgenerate

   logic [PRE_SEL_W-1:0] pre_q;
   logic [BRP_W-1:0]     brp_q;
   logic [SEG_W-1:0]     prop_q, ph1_q, ph2_q;
   logic [SJW_W-1:0]     sjw_q;
   logic                 run, restart, rx_s, fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= '0; brp_q <= '0; prop_q <= '0;
         ph1_q <= '0; ph2_q <= '0; sjw_q  <= '0;
      end else if (!enable) begin
         pre_q <= pre_sel; brp_q <= brp;     prop_q <= prop_len;
         ph1_q <= ph1_len; ph2_q <= ph2_len; sjw_q  <= sjw_len;
      end
   end

   bt_cfg_check #(
      .PRE_SEL_W(PRE_SEL_W), .PRE_MAX_LOG(PRE_MAX_LOG), .SEG_W(SEG_W),
      .SJW_W(SJW_W), .MIN_BIT_TQ(MIN_BIT_TQ), .MAX_BIT_TQ(MAX_BIT_TQ)
   ) u_check (
      .pre_sel(pre_q), .prop_len(prop_q), .ph1_len(ph1_q),
      .ph2_len(ph2_q), .sjw_len(sjw_q), .bad(cfg_bad)
   );

   assign run = enable & ~cfg_bad;

   bt_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .rx(rx), .rx_s(rx_s), .fall(fall)
   );

   bt_prescale #(
      .PRE_SEL_W(PRE_SEL_W), .PRE_MAX_LOG(PRE_MAX_LOG), .BRP_W(BRP_W)
   ) u_prescale (
      .clk(clk), .rst_n(rst_n), .run(run), .restart(restart),
      .pre_sel(pre_q), .brp(brp_q), .tick(tq_tick)
   );

   bt_seq #(.SEG_W(SEG_W), .SJW_W(SJW_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .run(run), .tick(tq_tick), .fall(fall),
      .rx_s(rx_s), .prop_len(prop_q), .ph1_len(ph1_q), .ph2_len(ph2_q),
      .sjw_len(sjw_q), .restart(restart), .sample_stb(sample_stb),
      .sample_bit(sample_bit), .bit_start(bit_start)
   );

   AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && $past(enable)) |->
         ($stable(pre_q) && $stable(brp_q) && $stable(prop_q) &&
          $stable(ph1_q) && $stable(ph2_q) && $stable(sjw_q))); // R1
   AST_BAD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_bad |-> (!sample_stb && !bit_start && !tq_tick)); // R2
endmodule

// File: tb/can_bit_timing_test.sv
module can_bit_timing_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       enable = 1'b0;
   logic [2:0] pre_sel = '0;
   logic [3:0] brp = '0;
   logic [2:0] prop_len = '0, ph1_len = '0, ph2_len = '0;
   logic [1:0] sjw_len = '0;
   logic       rx = 1'b1;
   logic       tq_tick, sample_stb, sample_bit, bit_start, cfg_bad;

   int checks = 0;
   int errors = 0;
   int dbl_pulse = 0;
   int overlap = 0;
   logic prev_s = 1'b0, prev_b = 1'b0;

   always #2.5 clk = ~clk;

   can_bit_timing uut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .pre_sel(pre_sel), .brp(brp),
      .prop_len(prop_len), .ph1_len(ph1_len), .ph2_len(ph2_len),
      .sjw_len(sjw_len), .rx(rx), .tq_tick(tq_tick), .sample_stb(sample_stb),
      .sample_bit(sample_bit), .bit_start(bit_start), .cfg_bad(cfg_bad)
   );

   // fields: pre_sel(3) brp(4) prop(3) ph1(3) ph2(3) sjw(2) expected cfg_bad(1)
   localparam int NV = 12;
   localparam logic [18:0] CFG_VEC [NV] = '{
      {3'd0, 4'd0, 3'd2, 3'd3, 3'd2, 2'd1, 1'b0},  // baseline legal
      {3'd0, 4'd0, 3'd2, 3'd2, 3'd3, 2'd0, 1'b1},  // ph1 < ph2
      {3'd0, 4'd0, 3'd2, 3'd2, 3'd1, 2'd3, 1'b1},  // ph1 < sjw
      {3'd0, 4'd0, 3'd7, 3'd7, 3'd0, 2'd0, 1'b1},  // sjw 1, ph2 of 1
      {3'd0, 4'd0, 3'd2, 3'd3, 3'd1, 2'd2, 1'b1},  // sjw 3, ph2 of 2
      {3'd0, 4'd0, 3'd2, 3'd3, 3'd1, 2'd1, 1'b0},  // sjw 2, ph2 of 2
      {3'd0, 4'd0, 3'd0, 3'd2, 3'd1, 2'd0, 1'b1},  // total 7
      {3'd0, 4'd0, 3'd1, 3'd2, 3'd1, 2'd0, 1'b0},  // total 8
      {3'd0, 4'd0, 3'd7, 3'd7, 3'd7, 2'd3, 1'b0},  // total 25
      {3'd5, 4'd0, 3'd2, 3'd3, 3'd2, 2'd1, 1'b1},  // predivider select too big
      {3'd4, 4'd0, 3'd2, 3'd3, 3'd2, 2'd1, 1'b0},  // largest predivider
      {3'd0, 4'd0, 3'd7, 3'd0, 3'd0, 2'd0, 1'b1}   // ph1 of 1
   };

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_cfg(input logic [2:0] ps, input logic [3:0] bp,
                          input logic [2:0] pr, input logic [2:0] p1,
                          input logic [2:0] p2, input logic [1:0] sj);
      pre_sel = ps; brp = bp; prop_len = pr; ph1_len = p1; ph2_len = p2; sjw_len = sj;
   endtask

   task automatic tick_period(output int per);
      int t = 0, first = -1;
      per = -1;
      while (t < 400) begin
         @(negedge clk); t++;
         if (tq_tick) begin
            if (first < 0) first = t;
            else begin per = t - first; break; end
         end
      end
   endtask

   // Called at the negedge on which bit_start is seen; ends on the next one.
   task automatic run_bit(input string req, input logic rx0, input int f1,
                          input int r1, input int f2, input int exp_len,
                          input int exp_samp, input int exp_bit);
      int k = 0, samp_at = -1, sb = -1;
      rx = rx0;
      if (f1 == 0) rx = 1'b0;
      forever begin
         @(negedge clk); k++;
         if (k == f1) rx = 1'b0;
         if (k == r1) rx = 1'b1;
         if (k == f2) rx = 1'b0;
         if (sample_stb) begin samp_at = k; sb = int'(sample_bit); end
         if (bit_start || k > 300) break;
      end
      chk({req, " bit length"}, k, exp_len);
      chk({req, " sample offset"}, samp_at, exp_samp);
      chk({req, " sampled value"}, sb, exp_bit);
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         if (sample_stb && prev_s) dbl_pulse++;
         if (bit_start && prev_b)  dbl_pulse++;
         if (sample_stb && bit_start) overlap++;
      end
      prev_s = sample_stb;
      prev_b = bit_start;
   end

   initial begin
      #(150000 * 5);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int cnt_t, cnt_s, cnt_b, per;
      // reset state
      wait_cyc(3);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R2 reset cfg_bad", int'(cfg_bad), 1);
      chk("R3 reset tq_tick", int'(tq_tick), 0);
      chk("R5 reset sample_stb", int'(sample_stb), 0);
      chk("R4 reset bit_start", int'(bit_start), 0);

      // legality table
      for (int i = 0; i < NV; i++) begin
         set_cfg(CFG_VEC[i][18:16], CFG_VEC[i][15:12], CFG_VEC[i][11:9],
                 CFG_VEC[i][8:6], CFG_VEC[i][5:3], CFG_VEC[i][2:1]);
         wait_cyc(2);
         chk($sformatf("R2 legality vector %0d", i), int'(cfg_bad), int'(CFG_VEC[i][0]));
      end

      // illegal configuration while enabled: silent
      set_cfg(3'd0, 4'd0, 3'd2, 3'd2, 3'd3, 2'd0);
      wait_cyc(2);
      enable = 1'b1;
      cnt_t = 0; cnt_s = 0; cnt_b = 0;
      for (int i = 0; i < 120; i++) begin
         @(negedge clk);
         rx = i[3];
         if (tq_tick) cnt_t++;
         if (sample_stb) cnt_s++;
         if (bit_start) cnt_b++;
      end
      chk("R2 halted ticks", cnt_t, 0);
      chk("R2 halted samples", cnt_s, 0);
      chk("R2 halted bit starts", cnt_b, 0);
      enable = 1'b0; rx = 1'b1;

      // quantum period
      set_cfg(3'd0, 4'd1, 3'd2, 3'd3, 3'd2, 2'd1);
      wait_cyc(2); enable = 1'b1; tick_period(per); enable = 1'b0;
      chk("R3 period sel0 brp1", per, 4);
      set_cfg(3'd2, 4'd2, 3'd2, 3'd3, 3'd2, 2'd1);
      wait_cyc(2); enable = 1'b1; tick_period(per); enable = 1'b0;
      chk("R3 period sel2 brp2", per, 24);
      set_cfg(3'd4, 4'd0, 3'd2, 3'd3, 3'd2, 2'd1);
      wait_cyc(2); enable = 1'b1; tick_period(per); enable = 1'b0;
      chk("R3 period sel4 brp0", per, 32);

      // main config: Tq = 4 cycles, prop 3, ph1 4, ph2 3, sjw 2
      set_cfg(3'd0, 4'd1, 3'd2, 3'd3, 3'd2, 2'd1);
      wait_cyc(2);
      enable = 1'b1;
      cnt_b = 0;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (bit_start) cnt_b++;
      end
      chk("R4 idle without edge", cnt_b, 0);

      // hard synchronization
      rx = 1'b0;
      @(negedge clk); cnt_b = int'(bit_start);
      @(negedge clk); cnt_b += int'(bit_start);
      chk("R4 no early bit start", cnt_b, 0);
      @(negedge clk);
      chk("R4 hard sync bit start", int'(bit_start), 1);

      run_bit("R5 first bit", 1'b0, -1, -1, -1, 44, 32, 0);

      // inputs change while enabled: no effect
      set_cfg(3'd6, 4'd9, 3'd0, 3'd0, 3'd0, 2'd3);
      run_bit("R1 recessive bit", 1'b1, -1, -1, -1, 44, 32, 1);
      chk("R1 cfg_bad held", int'(cfg_bad), 0);
      set_cfg(3'd0, 4'd1, 3'd2, 3'd3, 3'd2, 2'd1);

      run_bit("R6 edge in sync", 1'b1, 0, -1, -1, 44, 32, 0);
      run_bit("R7 late e1", 1'b1, 3, -1, -1, 48, 36, 0);
      run_bit("R7 late e2", 1'b1, 7, -1, -1, 52, 40, 0);
      run_bit("R7 late capped", 1'b1, 15, -1, -1, 52, 40, 0);
      run_bit("R9 second edge", 1'b1, 3, 8, 19, 48, 36, 0);
      run_bit("R8 early capped", 1'b1, 31, -1, -1, 36, 32, 1);
      run_bit("R8 early r2", 1'b1, 35, -1, -1, 40, 32, 1);

      chk("R10 pulse widths", dbl_pulse, 0);
      chk("R10 strobe overlap", overlap, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule